// File: doc/BRIEF.md
# Nested Priority Interrupt Controller

This block collects a set of interrupt request lines and tells a processor which one to serve next. Each source has a programmable priority value in which a smaller number means more urgent. The value is split into an upper preemption part and a lower subpriority part, and a grouping register sets where the split falls. The controller offers the best eligible request as a vector index. The processor accepts the offer with a one-cycle take strobe.

Accepted requests become active handlers and go onto a nesting stack. A request can interrupt the running handler only when its preemption part is strictly smaller than that handler's. The subpriority only orders requests that are waiting together. When the processor pulses the end-of-handler strobe, the top handler leaves the stack and the interrupted one runs again. If another request is waiting at that moment, it can be taken in the same cycle and replace the finishing handler directly.

A global threshold can hold back every request that is not more urgent than a programmed value, without changing the per-source enables. All configuration goes through a simple address, data and write-enable port.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset there is no offered request, no running handler and a stack depth of 0. All priorities read as 0, all sources are disabled, the threshold is off and the split is PRE_BITS preemption bits.
- R2: A source's pending flag is set on a rising edge of its request line, even while the source is disabled. Only pending sources whose bit is set in the enable register (address N_SRC, bit i = source i) are offered. Taking a request clears its pending flag.
- R3: Among eligible sources, the one with the numerically smallest priority is offered. Equal priorities are resolved toward the lowest source index.
- R4: Address i (0 to N_SRC-1) holds source i's priority in its low PW bits. Address N_SRC+2 holds the number G of preemption bits (0 to PW), which are the top G bits of the priority. A written value above PW acts as PW.
- R5: While a handler runs, a request is offered only if its preemption part is strictly smaller than the running handler's. Subpriority alone never causes preemption.
- R6: Address N_SRC+1 holds the threshold: bit PW turns it on and bits PW-1:0 hold the value. While it is on, a source whose priority is greater than or equal to the value is not offered.
- R7: An end-of-handler strobe removes the top handler, and the interrupted handler is reported as running again.
- R8: During an end-of-handler cycle, the offer is judged against the level below the finishing handler. A take in that same cycle replaces the finishing handler, so the running indication never drops.
- R9: A take pushes the offered source onto the stack as the running handler. The depth never exceeds 2^PW.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_i | input | N_SRC | Request lines, one per source |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | clog2(N_SRC+3) | Configuration address |
| cfg_wdata_i | input | max(N_SRC, PW+1) | Configuration write data |
| req_valid_o | output | 1 | A request is offered to the processor |
| req_vec_o | output | clog2(N_SRC) | Index of the offered source |
| req_take_i | input | 1 | Processor accepts the offered request |
| eoi_i | input | 1 | End of the running handler |
| run_valid_o | output | 1 | A handler is active |
| run_vec_o | output | clog2(N_SRC) | Index of the running (top) handler |
| depth_o | output | clog2(2^PW+1) | Number of nested active handlers |

## Verification
The assertions check the following on every cycle:
- an offered source is enabled, pending and below an active threshold;
- the arbiter never passes over a more urgent eligible source;
- a take makes the offered source the running handler;
- every nested push holds a strictly smaller preemption part than the handler beneath it;
- a completion reveals the handler below;
- a combined completion and take keeps the depth unchanged;
- the stack neither overflows nor underflows.

Only the bench scenarios can show that the arbitration choice is correct over the whole priority space. The same goes for preemption decisions under every grouping split, threshold boundaries, and tail-chained hand-over in the same cycle as the end strobe.

// File: rtl/irq_nest_pkg.sv
package irq_nest_pkg;
  // which configuration target a write selects
  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_PRIO,
    SEL_ENABLE,
    SEL_THRESH,
    SEL_GROUP
  } cfg_sel_e;
endpackage

// File: rtl/irq_nest_cfg.sv
module irq_nest_cfg
  import irq_nest_pkg::*;
#(
  parameter int N_SRC   = 8,
  parameter int PW      = 4,
  parameter int GW      = 3,
  parameter int AW      = 4,
  parameter int DW      = 8,
  parameter int PRE_RST = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     we_i,
  input  logic [AW-1:0]            addr_i,
  input  logic [DW-1:0]            wdata_i,
  output logic [N_SRC-1:0][PW-1:0] prio_o,
  output logic [N_SRC-1:0]         en_o,
  output logic                     thr_en_o,
  output logic [PW-1:0]            thr_o,
  output logic [GW-1:0]            grp_o
);
  localparam logic [AW-1:0] A_EN  = AW'(N_SRC);
  localparam logic [AW-1:0] A_THR = AW'(N_SRC + 1);
  localparam logic [AW-1:0] A_GRP = AW'(N_SRC + 2);

  cfg_sel_e      sel;
  logic [GW-1:0] grp_d;

  always_comb begin
    sel = SEL_NONE;
    if (we_i) begin
      if (addr_i < A_EN)       sel = SEL_PRIO;
      else if (addr_i == A_EN)  sel = SEL_ENABLE;
      else if (addr_i == A_THR) sel = SEL_THRESH;
      else if (addr_i == A_GRP) sel = SEL_GROUP;
    end
  end

  // grouping value saturates at the full priority width
  always_comb begin
    grp_d = wdata_i[GW-1:0];
    if (wdata_i[GW-1:0] > GW'(PW)) grp_d = GW'(PW);
  end

  for (genvar i = 0; i < N_SRC; i++) begin : g_prio
    logic prio_we;
    assign prio_we = (sel == SEL_PRIO) && (addr_i == AW'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       prio_o[i] <= '0;
      else if (prio_we) prio_o[i] <= wdata_i[PW-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  en_o <= '0;
    else if (sel == SEL_ENABLE)  en_o <= wdata_i[N_SRC-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      thr_en_o <= 1'b0;
      thr_o    <= '0;
    end else if (sel == SEL_THRESH) begin
      thr_en_o <= wdata_i[PW];
      thr_o    <= wdata_i[PW-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 grp_o <= GW'(PRE_RST);
    else if (sel == SEL_GROUP)  grp_o <= grp_d;
  end

  a_r4_group_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    grp_o <= GW'(PW));
endmodule

// File: rtl/irq_nest_pend.sv
module irq_nest_pend #(
  parameter int N_SRC = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] irq_i,
  input  logic [N_SRC-1:0] clr_i,
  output logic [N_SRC-1:0] pend_o
);
  logic [N_SRC-1:0] irq_q;
  logic [N_SRC-1:0] rise;
  logic [N_SRC-1:0] pend_d;

  always_comb begin
    rise   = irq_i & ~irq_q;
    pend_d = (pend_o & ~clr_i) | rise;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q  <= '0;
      pend_o <= '0;
    end else begin
      irq_q  <= irq_i;
      pend_o <= pend_d;
    end
  end

  for (genvar i = 0; i < N_SRC; i++) begin : g_chk
    a_r2_edge_latches: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_i[i] && !irq_q[i]) |=> pend_o[i]);
  end
endmodule

// File: rtl/irq_nest_arb.sv
module irq_nest_arb #(
  parameter int N_SRC = 8,
  parameter int PW    = 4,
  parameter int IW    = 3
) (
  input  logic [N_SRC-1:0]         elig_i,
  input  logic [N_SRC-1:0][PW-1:0] prio_i,
  output logic                     valid_o,
  output logic [IW-1:0]            idx_o,
  output logic [PW-1:0]            best_o
);
  logic          v;
  logic [IW-1:0] ix;
  logic [PW-1:0] bp;

  // strict compare keeps the earlier (lower) index on equal priority
  always_comb begin
    v  = 1'b0;
    ix = '0;
    bp = '1;
    for (int i = 0; i < N_SRC; i++) begin
      if (elig_i[i] && (!v || prio_i[i] < bp)) begin
        v  = 1'b1;
        ix = IW'(i);
        bp = prio_i[i];
      end
    end
    valid_o = v;
    idx_o   = ix;
    best_o  = bp;
  end

  always_comb begin
    for (int j = 0; j < N_SRC; j++) begin
      if (valid_o && elig_i[j]) begin
        a_r3_none_better: assert (!(prio_i[j] < best_o) &&
                                  !(prio_i[j] == best_o && IW'(j) < idx_o));
      end
    end
  end
endmodule

// File: rtl/irq_nest_stack.sv
module irq_nest_stack #(
  parameter int IW    = 3,
  parameter int PW    = 4,
  parameter int DEPTH = 16,
  parameter int DPW   = 5
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           push_i,
  input  logic           pop_i,
  input  logic [IW-1:0]  push_vec_i,
  input  logic [PW-1:0]  push_prio_i,
  output logic [DPW-1:0] depth_o,
  output logic [IW-1:0]  top_vec_o,
  output logic [PW-1:0]  top_prio_o,
  output logic [IW-1:0]  below_vec_o,
  output logic [PW-1:0]  below_prio_o
);
  localparam int XW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [IW-1:0]  vec_q  [DEPTH];
  logic [PW-1:0]  prio_q [DEPTH];
  logic [DPW-1:0] depth_d;
  logic [XW-1:0]  wr_idx;
  logic [XW-1:0]  top_idx;
  logic [XW-1:0]  below_idx;

  always_comb begin
    top_idx   = XW'(depth_o - DPW'(1));
    below_idx = XW'(depth_o - DPW'(2));
    // a push together with a pop overwrites the finishing entry
    wr_idx    = pop_i ? top_idx : XW'(depth_o);
    depth_d   = depth_o + DPW'(push_i) - DPW'(pop_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < DEPTH; k++) begin
        vec_q[k]  <= '0;
        prio_q[k] <= '0;
      end
    end else if (push_i) begin
      vec_q[wr_idx]  <= push_vec_i;
      prio_q[wr_idx] <= push_prio_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                depth_o <= '0;
    else if (push_i || pop_i)  depth_o <= depth_d;
  end

  assign top_vec_o    = vec_q[top_idx];
  assign top_prio_o   = prio_q[top_idx];
  assign below_vec_o  = vec_q[below_idx];
  assign below_prio_o = prio_q[below_idx];

  a_r9_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && !pop_i) |-> depth_o < DPW'(DEPTH));
  a_r9_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    pop_i |-> depth_o != '0);
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl #(
  parameter  int N_SRC    = 8,
  parameter  int PRE_BITS = 2,
  parameter  int SUB_BITS = 2,
  localparam int PW       = PRE_BITS + SUB_BITS,
  localparam int IW       = $clog2(N_SRC),
  localparam int AW       = $clog2(N_SRC + 3),
  localparam int DW       = (N_SRC > PW) ? N_SRC : PW + 1,
  localparam int DEPTH    = 1 << PW,
  localparam int DPW      = $clog2(DEPTH + 1),
  localparam int GW       = $clog2(PW + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] irq_i,
  input  logic             cfg_we_i,
  input  logic [AW-1:0]    cfg_addr_i,
  input  logic [DW-1:0]    cfg_wdata_i,
  output logic             req_valid_o,
  output logic [IW-1:0]    req_vec_o,
  input  logic             req_take_i,
  input  logic             eoi_i,
  output logic             run_valid_o,
  output logic [IW-1:0]    run_vec_o,
  output logic [DPW-1:0]   depth_o
);
  logic [N_SRC-1:0][PW-1:0] prio;
  logic [N_SRC-1:0]         en;
  logic                     thr_en;
  logic [PW-1:0]            thr;
  logic [GW-1:0]            grp;
  logic [N_SRC-1:0]         pend;
  logic [N_SRC-1:0]         clr;
  logic [N_SRC-1:0]         elig;
  logic                     arb_valid;
  logic [IW-1:0]            best_idx;
  logic [PW-1:0]            best_prio;
  logic [IW-1:0]            top_vec;
  logic [PW-1:0]            top_prio;
  logic [IW-1:0]            below_vec;
  logic [PW-1:0]            below_prio;
  logic                     busy;
  logic                     pop;
  logic                     push;
  logic                     ref_valid;
  logic [PW-1:0]            ref_prio;

  function automatic logic [PW-1:0] pre_of(input logic [PW-1:0] p,
                                           input logic [GW-1:0] g);
    return p >> (PW - int'(g));
  endfunction

  irq_nest_cfg #(
    .N_SRC(N_SRC), .PW(PW), .GW(GW), .AW(AW), .DW(DW), .PRE_RST(PRE_BITS)
  ) u_cfg (
    .clk(clk), .rst_n(rst_n), .we_i(cfg_we_i), .addr_i(cfg_addr_i),
    .wdata_i(cfg_wdata_i), .prio_o(prio), .en_o(en), .thr_en_o(thr_en),
    .thr_o(thr), .grp_o(grp)
  );

  irq_nest_pend #(.N_SRC(N_SRC)) u_pend (
    .clk(clk), .rst_n(rst_n), .irq_i(irq_i), .clr_i(clr), .pend_o(pend)
  );

  always_comb begin
    for (int i = 0; i < N_SRC; i++) begin
      elig[i] = pend[i] && en[i] && (!thr_en || (prio[i] < thr));
    end
  end

  irq_nest_arb #(.N_SRC(N_SRC), .PW(PW), .IW(IW)) u_arb (
    .elig_i(elig), .prio_i(prio), .valid_o(arb_valid),
    .idx_o(best_idx), .best_o(best_prio)
  );

  irq_nest_stack #(.IW(IW), .PW(PW), .DEPTH(DEPTH), .DPW(DPW)) u_stack (
    .clk(clk), .rst_n(rst_n), .push_i(push), .pop_i(pop),
    .push_vec_i(best_idx), .push_prio_i(best_prio), .depth_o(depth_o),
    .top_vec_o(top_vec), .top_prio_o(top_prio),
    .below_vec_o(below_vec), .below_prio_o(below_prio)
  );

  // on an end strobe the candidate competes with the level underneath
  always_comb begin
    busy      = (depth_o != '0);
    pop       = eoi_i && busy;
    ref_valid = eoi_i ? (depth_o >= DPW'(2)) : busy;
    ref_prio  = eoi_i ? below_prio : top_prio;
    req_valid_o = arb_valid &&
                  (!ref_valid || (pre_of(best_prio, grp) < pre_of(ref_prio, grp)));
    req_vec_o = best_idx;
    push      = req_valid_o && req_take_i;
    clr       = push ? (N_SRC'(1) << best_idx) : '0;
  end

  assign run_valid_o = busy;
  assign run_vec_o   = top_vec;

  a_r9_take_runs: assert property (@(posedge clk) disable iff (!rst_n)
    push |=> run_valid_o && (run_vec_o == $past(req_vec_o)));
  a_r2_offer_enabled: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid_o |-> en[req_vec_o] && pend[req_vec_o]);
  a_r6_below_threshold: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_o && thr_en) |-> prio[req_vec_o] < thr);
  a_r5_strict_nesting: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop && busy && !cfg_we_i) |=>
      pre_of(top_prio, grp) < pre_of(below_prio, grp));
  a_r7_resume_prev: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !push && depth_o >= DPW'(2)) |=> run_vec_o == $past(below_vec));
  a_r8_tail_no_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && push) |=> run_valid_o && (depth_o == $past(depth_o)));
endmodule

// File: tb/prio_irq_ctrl_bench.sv
module prio_irq_ctrl_bench;
  localparam int N   = 4;
  localparam int PW  = 4;
  localparam int A_EN  = 4;
  localparam int A_THR = 5;
  localparam int A_GRP = 6;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [3:0] irq;
  logic       cfg_we;
  logic [2:0] cfg_addr;
  logic [4:0] cfg_wdata;
  logic       req_valid;
  logic [1:0] req_vec;
  logic       req_take;
  logic       eoi;
  logic       run_valid;
  logic [1:0] run_vec;
  logic [4:0] depth;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;

  prio_irq_ctrl #(.N_SRC(N), .PRE_BITS(2), .SUB_BITS(2)) u_prio_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .irq_i(irq), .cfg_we_i(cfg_we),
    .cfg_addr_i(cfg_addr), .cfg_wdata_i(cfg_wdata), .req_valid_o(req_valid),
    .req_vec_o(req_vec), .req_take_i(req_take), .eoi_i(eoi),
    .run_valid_o(run_valid), .run_vec_o(run_vec), .depth_o(depth)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic wr(input int a, input int d);
    cfg_we = 1'b1; cfg_addr = 3'(a); cfg_wdata = 5'(d);
    tick();
    cfg_we = 1'b0;
    #1;
  endtask

  task automatic pulse(input int s);
    irq[s] = 1'b1;
    tick();
    irq[s] = 1'b0;
    #1;
  endtask

  task automatic take();
    req_take = 1'b1;
    tick();
    req_take = 1'b0;
    #1;
  endtask

  task automatic end_handler();
    eoi = 1'b1;
    tick();
    eoi = 1'b0;
    #1;
  endtask

  task automatic drain();
    for (int k = 0; k < 8; k++) begin
      if (run_valid) end_handler();
      if (req_valid) take();
    end
  endtask

  initial begin
    rst_n = 1'b0; irq = '0; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
    req_take = 1'b0; eoi = 1'b0;
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    #1;
    chk("R1 req_valid", int'(req_valid), 0);
    chk("R1 run_valid", int'(run_valid), 0);
    chk("R1 depth", int'(depth), 0);

    // pending latches while disabled, nothing is offered
    pulse(0);
    chk("R2 disabled source", int'(req_valid), 0);
    pulse(1);
    wr(A_EN, 3);
    chk("R1/R2 enabled offer", int'(req_valid), 1);
    chk("R1 default priority tie", int'(req_vec), 0);

    // exhaustive two-source arbitration
    for (int a = 0; a < 16; a++) begin
      for (int b = 0; b < 16; b++) begin
        wr(0, a);
        wr(1, b);
        chk("R3 pair valid", int'(req_valid), 1);
        chk("R3 pair winner", int'(req_vec), (b < a) ? 1 : 0);
      end
    end

    // four-way tie then peel off the lowest indices
    for (int s = 0; s < 4; s++) wr(s, 7);
    pulse(2);
    pulse(3);
    wr(A_EN, 15);
    chk("R3 four-way tie", int'(req_vec), 0);
    wr(0, 9);
    chk("R3 tie after demote 0", int'(req_vec), 1);
    wr(1, 9);
    chk("R3 tie after demote 1", int'(req_vec), 2);
    take();
    chk("R9 running after take", int'(run_vec), 2);
    chk("R5 same group waits", int'(req_valid), 0);
    drain();
    chk("R2 all pending cleared", int'(req_valid), 0);
    chk("R7 stack emptied", int'(depth), 0);

    // threshold sweep around priority 5
    wr(A_EN, 1);
    wr(0, 5);
    pulse(0);
    for (int t = 0; t < 16; t++) begin
      wr(A_THR, 16 | t);
      chk("R6 threshold", int'(req_valid), (5 < t) ? 1 : 0);
    end
    wr(A_THR, 0);
    chk("R6 threshold off", int'(req_valid), 1);
    take();
    end_handler();
    chk("R2 cleared after take", int'(req_valid), 0);

    // preemption and tail-chaining over every grouping split
    for (int g = 0; g <= PW; g++) begin
      wr(A_GRP, g);
      for (int pa = 0; pa < 16; pa++) begin
        for (int pb = 0; pb < 16; pb++) begin
          int exp_pre;
          exp_pre = ((pb >> (PW - g)) < (pa >> (PW - g))) ? 1 : 0;
          wr(0, pa);
          wr(1, pb);
          wr(A_EN, 1);
          pulse(0);
          take();
          chk("R9 first handler", int'(run_vec), 0);
          wr(A_EN, 3);
          pulse(1);
          chk("R5 preempt decision", int'(req_valid), exp_pre);
          if (exp_pre == 1) begin
            take();
            chk("R9 nested depth", int'(depth), 2);
            chk("R9 nested running", int'(run_vec), 1);
            end_handler();
            chk("R7 resume interrupted", int'(run_vec), 0);
            chk("R7 resume depth", int'(depth), 1);
            end_handler();
          end else begin
            eoi = 1'b1;
            #1;
            chk("R8 offered at end", int'(req_valid), 1);
            chk("R8 offered vector", int'(req_vec), 1);
            req_take = 1'b1;
            tick();
            eoi = 1'b0;
            req_take = 1'b0;
            #1;
            chk("R8 no idle gap", int'(run_valid), 1);
            chk("R8 chained handler", int'(run_vec), 1);
            chk("R8 chained depth", int'(depth), 1);
            end_handler();
          end
          chk("R7 idle after iteration", int'(depth), 0);
        end
      end
    end

    // group write above range behaves as full width
    wr(A_GRP, 7);
    wr(0, 1);
    wr(1, 0);
    wr(A_EN, 1);
    pulse(0);
    take();
    wr(A_EN, 3);
    pulse(1);
    chk("R4 clamped group preempts", int'(req_valid), 1);
    drain();

    // four deep nesting and unwinding
    wr(A_GRP, 2);
    wr(0, 12); wr(1, 8); wr(2, 4); wr(3, 0);
    wr(A_EN, 15);
    for (int s = 0; s < 4; s++) begin
      pulse(s);
      chk("R5 deeper preempts", int'(req_valid), 1);
      take();
    end
    chk("R9 depth four", int'(depth), 4);
    chk("R9 top running", int'(run_vec), 3);
    for (int s = 2; s >= 0; s--) begin
      end_handler();
      chk("R7 unwind", int'(run_vec), s);
    end
    end_handler();
    chk("R7 fully unwound", int'(run_valid), 0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: got %0d expected %0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule